// File: doc/BRIEF.md
# Shared Interrupt Affinity Routing Table

This block holds one routing register per shared interrupt. Software writes a target affinity into an entry. The block keeps that word so that a read returns exactly what was written. It also resolves the affinity to a local CPU index through a table of CPU affinities that the surrounding logic supplies.

From the resolved index and its valid flag, the block produces a per-CPU bitmap of the shared interrupts routed to each CPU. An affinity that names no CPU still leaves the entry readable as written, but routes the interrupt to nobody.

Each entry occupies 8 bytes of the register window. Entry n starts at byte offset n*8. The low word at offset +0 carries the affinity. The high word at offset +4 is reserved.

Top module: `irq_route_table`

## Requirements
- R1: After reset, every entry has target index 0 and valid 1. Every bit of CPU 0's map is set and every other map is empty. A read of any low word returns the affinity of table slot 0.
- R2: A read of an entry's low word (offset n*8) returns the 32-bit word last written there, whether or not that word matched a CPU.
- R3: The high word (offset n*8+4) always reads zero. A write to it changes no target, flag, map or stored word.
- R4: A write to a low word whose data equals a table slot's affinity sets that entry's target index to the slot number and valid to 1. The change is visible after the next rising clock edge.
- R5: When several table slots hold the written affinity, the lowest-numbered slot is chosen.
- R6: A write whose data equals no table slot clears valid and sets the target index to 8'hFF (not allocated). The entry then appears in no CPU map.
- R7: The map of CPU c (cpu_map_o bits c*NUM_SPI+n) has bit n set exactly when entry n is valid with index c. A retarget clears the old bit and sets the new bit at the same clock edge, so no entry ever appears in two maps.
- R8: A write alters only the addressed entry. Cycles without req_i and we_i both high, and all reads, leave every target unchanged.
- R9: Accesses at offsets that are not word aligned (addr_i[1:0] != 0), or that lie beyond the last entry, are ignored on writes and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the routing window |
| wdata_i | input | 32 | Write data (affinity: level 0 in 7:0, 1 in 15:8, 2 in 23:16, 3 in 31:24) |
| rdata_o | output | 32 | Read data, combinational, zero when no read is requested |
| cpu_aff_i | input | NUM_CPU*32 | Affinity of each CPU slot c at bits c*32 +: 32 |
| tgt_idx_o | output | NUM_SPI*8 | Target CPU index of entry n at bits n*8 +: 8 |
| tgt_vld_o | output | NUM_SPI | Entry n routes to an existing CPU |
| cpu_map_o | output | NUM_CPU*NUM_SPI | Per-CPU bitmap of routed entries |

## Verification
The following properties are checked on every cycle:
- At most one CPU map claims each entry.
- A valid entry appears in the map its index names.
- An invalid entry carries the not-allocated code.
- High-word, misaligned and out-of-range reads return zero.
- Targets hold still across cycles with no write and across high-word writes.

The bench scenarios cover the rest:
- The reset defaults.
- Which slot a given affinity resolves to, and the lowest-slot rule for duplicates.
- Read-back of unmatched words.
- Confirmation that a write touched only its own entry.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned CPU_IDX_W = 8;
  localparam int unsigned AFF_W     = 32;
  typedef logic [AFF_W-1:0]     aff_t;
  typedef logic [CPU_IDX_W-1:0] cpu_idx_t;
  localparam cpu_idx_t CPU_NONE = '1;
  typedef struct packed {
    logic     vld;
    cpu_idx_t idx;
  } route_t;
endpackage

// File: rtl/aff_lookup.sv
module aff_lookup
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8
) (
  input  aff_t                     key_i,
  input  logic [NUM_CPU*AFF_W-1:0] table_i,
  output logic                     hit_o,
  output cpu_idx_t                 idx_o
);
  // descending scan: the lowest matching slot is assigned last and wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = CPU_NONE;
    for (int c = NUM_CPU - 1; c >= 0; c--) begin
      if (table_i[c*AFF_W +: AFF_W] == key_i) begin
        hit_o = 1'b1;
        idx_o = CPU_IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/route_entry.sv
module route_entry
  import irq_route_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  aff_t     wdata_i,
  input  logic     hit_i,
  input  cpu_idx_t idx_i,
  input  aff_t     boot_aff_i,
  output aff_t     aff_o,
  output route_t   route_o
);
  logic   boot_q;
  aff_t   aff_q;
  route_t route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q  <= 1'b1;
      aff_q   <= '0;
      route_q <= '{vld: 1'b1, idx: '0};
    end else if (wr_i) begin
      boot_q  <= 1'b0;
      aff_q   <= wdata_i;
      route_q <= hit_i ? '{vld: 1'b1, idx: idx_i} : '{vld: 1'b0, idx: CPU_NONE};
    end
  end

  // until first written, the entry mirrors slot 0's affinity
  assign aff_o   = boot_q ? boot_aff_i : aff_q;
  assign route_o = route_q;
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SPI = 32,
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned ADDR_W  = $clog2(NUM_SPI * 8)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  input  logic [NUM_CPU*AFF_W-1:0]     cpu_aff_i,
  output logic [NUM_SPI*CPU_IDX_W-1:0] tgt_idx_o,
  output logic [NUM_SPI-1:0]           tgt_vld_o,
  output logic [NUM_CPU*NUM_SPI-1:0]   cpu_map_o
);
  localparam int unsigned SEL_W = ADDR_W - 3;

  logic [SEL_W-1:0] sel;
  logic             in_range, aligned, lo_word, wr_lo;
  logic             hit;
  cpu_idx_t         hit_idx;
  aff_t             aff_w   [NUM_SPI];
  route_t           route_w [NUM_SPI];

  assign sel      = addr_i[ADDR_W-1:3];
  assign in_range = 32'(sel) < NUM_SPI;
  assign aligned  = addr_i[1:0] == 2'b00;
  assign lo_word  = in_range && aligned && !addr_i[2];
  assign wr_lo    = req_i && we_i && lo_word;

  // one shared comparator bank: at most one write per cycle
  aff_lookup #(.NUM_CPU(NUM_CPU)) u_lookup (
    .key_i   (wdata_i),
    .table_i (cpu_aff_i),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_entry
    route_entry u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_lo && (32'(sel) == s)),
      .wdata_i    (wdata_i),
      .hit_i      (hit),
      .idx_i      (hit_idx),
      .boot_aff_i (cpu_aff_i[AFF_W-1:0]),
      .aff_o      (aff_w[s]),
      .route_o    (route_w[s])
    );
    assign tgt_idx_o[s*CPU_IDX_W +: CPU_IDX_W] = route_w[s].idx;
    assign tgt_vld_o[s]                        = route_w[s].vld;
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_map
      assign cpu_map_o[c*NUM_SPI + s] = route_w[s].vld && (route_w[s].idx == CPU_IDX_W'(c));
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && lo_word) rdata_o = aff_w[sel];
  end
endmodule

// File: rtl/irq_route_table_chk.sv
module irq_route_table_chk #(
  parameter int unsigned NUM_SPI = 32,
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned ADDR_W  = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [31:0]                rdata_o,
  input logic [NUM_SPI*8-1:0]       tgt_idx_o,
  input logic [NUM_SPI-1:0]         tgt_vld_o,
  input logic [NUM_CPU*NUM_SPI-1:0] cpu_map_o
);
  logic rd_void;
  assign rd_void = addr_i[2] || (addr_i[1:0] != 2'b00) || (32'(addr_i[ADDR_W-1:3]) >= NUM_SPI);

  // R3 / R9: reserved, misaligned and out-of-range reads are zero
  a_r9_void_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && rd_void) |-> (rdata_o == 32'h0));

  a_r3_high_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[2]) |=> ($stable(tgt_idx_o) && $stable(tgt_vld_o)));

  a_r8_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(tgt_idx_o) && $stable(tgt_vld_o)));

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_spi
    logic [NUM_CPU-1:0] col;
    logic [7:0]         idx;
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_col
      assign col[c] = cpu_map_o[c*NUM_SPI + s];
    end
    assign idx = tgt_idx_o[s*8 +: 8];

    a_r7_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col));

    a_r7_map_follows_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tgt_vld_o[s] |-> ((32'(idx) < NUM_CPU) && ($countones(col) == 1) &&
                        cpu_map_o[32'(idx)*NUM_SPI + s]));

    a_r6_none_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tgt_vld_o[s] |-> ((idx == 8'hFF) && (col == '0)));
  end
endmodule

bind irq_route_table irq_route_table_chk #(
  .NUM_SPI(NUM_SPI), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .tgt_idx_o (tgt_idx_o),
  .tgt_vld_o (tgt_vld_o),
  .cpu_map_o (cpu_map_o)
);

// File: tb/irq_route_table_bench.sv
module irq_route_table_bench;
  localparam int NS = 6;
  localparam int NC = 4;
  localparam int AW = $clog2(NS * 8);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NC*32-1:0]  cpu_aff;
  logic [NS*8-1:0]   tgt_idx;
  logic [NS-1:0]     tgt_vld;
  logic [NC*NS-1:0]  cpu_map;

  int n_chk = 0, n_bad = 0;
  logic [31:0] tab [NC];
  logic [31:0] exp_aff [NS];
  logic [7:0]  exp_idx [NS];
  logic        exp_vld [NS];

  always #2 clk = ~clk;

  irq_route_table #(.NUM_SPI(NS), .NUM_CPU(NC)) u_irq_route_table (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cpu_aff_i(cpu_aff),
    .tgt_idx_o(tgt_idx), .tgt_vld_o(tgt_vld), .cpu_map_o(cpu_map)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req_tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input logic r, input logic w);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  // model: lowest slot holding the word, else not allocated
  task automatic model_write(input int s, input logic [31:0] d);
    exp_aff[s] = d;
    exp_vld[s] = 1'b0;
    exp_idx[s] = 8'hFF;
    for (int c = NC - 1; c >= 0; c--)
      if (tab[c] == d) begin exp_vld[s] = 1'b1; exp_idx[s] = 8'(c); end
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int s = 0; s < NS; s++) begin
      chk({tag, " R4 idx"}, 32'(tgt_idx[s*8 +: 8]), 32'(exp_idx[s]));
      chk({tag, " R6 vld"}, 32'(tgt_vld[s]), 32'(exp_vld[s]));
      for (int c = 0; c < NC; c++)
        chk({tag, " R7 map"}, 32'(cpu_map[c*NS + s]), 32'(exp_vld[s] && exp_idx[s] == 8'(c)));
      do_read(AW'(s*8), d);
      chk({tag, " R2 read"}, d, exp_aff[s]);
      do_read(AW'(s*8 + 4), d);
      chk({tag, " R3 high read"}, d, 32'h0);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    // slot 3 duplicates slot 1 for the lowest-slot rule
    tab[0] = 32'h0000_0100; tab[1] = 32'h0000_0101;
    tab[2] = 32'h0001_0000; tab[3] = 32'h0000_0101;
    for (int c = 0; c < NC; c++) cpu_aff[c*32 +: 32] = tab[c];
    for (int s = 0; s < NS; s++) begin exp_aff[s] = tab[0]; exp_idx[s] = 8'd0; exp_vld[s] = 1'b1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // R4 R5: sweep every entry through every slot
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) begin
        do_write(AW'(s*8), tab[c], 1'b1, 1'b1);
        model_write(s, tab[c]);
        check_all("R4 R5 sweep");
      end

    // R6: unmatched words, then back to a CPU
    for (int s = 0; s < NS; s++) begin
      do_write(AW'(s*8), 32'hDEAD_BEEF ^ 32'(s), 1'b1, 1'b1);
      model_write(s, 32'hDEAD_BEEF ^ 32'(s));
    end
    check_all("R6 unmatched");
    do_write(AW'(2*8), tab[2], 1'b1, 1'b1); model_write(2, tab[2]);
    do_write(AW'(4*8), 32'h0000_0102, 1'b1, 1'b1); model_write(4, 32'h0000_0102);
    check_all("R6 R8 mixed");

    // R3: high-word writes ignored
    for (int s = 0; s < NS; s++) do_write(AW'(s*8 + 4), tab[0], 1'b1, 1'b1);
    check_all("R3 high write");

    // R8: strobe or write-enable alone does nothing
    do_write(AW'(0), tab[1], 1'b0, 1'b1);
    do_write(AW'(8), tab[1], 1'b1, 1'b0);
    check_all("R8 no write");

    // R9: out of range and misaligned
    do_write(AW'(NS*8), tab[1], 1'b1, 1'b1);
    do_write(AW'(NS*8 + 8), tab[1], 1'b1, 1'b1);
    do_write(AW'(3*8 + 1), tab[1], 1'b1, 1'b1);
    do_write(AW'(5*8 + 2), tab[0], 1'b1, 1'b1);
    check_all("R9 void write");
    do_read(AW'(NS*8), d);    chk("R9 range read", d, 32'h0);
    do_read(AW'(2*8 + 1), d); chk("R9 misaligned read", d, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule